// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

This block produces a periodic interrupt from a slow 32768 Hz tick. The system clock runs the registers, and a one-cycle tick enable marks each slow-clock period. Software writes a reload value and then sets the run bit in the control register. The timer copies the reload value into a down-counter, which loses one on every tick. The tick that takes the counter through zero sets the raw interrupt flag and reloads the counter in the same cycle. The interrupt rate is therefore 32768 divided by the reload value. For example, a reload value of 4 gives 8192 Hz.

The register set has three words: the live count, the reload value and the control word. Reads are combinational and have no side effects. The raw flag is a single output. It is meant to sit in bit 1 of a shared interrupt status word, next to the alarm flag in bit 0. It stays set until a one-cycle clear pulse arrives.

Top module: `tmr_periodic`

## Requirements
- R1: After reset, the count, reload and control words all read 0 and the raw flag is low.
- R2: The register map decodes the full address. 0x20 reads the live count, 0x24 reads and writes the reload value, and 0x28 holds the control word, whose only bit is run in bit 1. Every other control bit reads 0, and any other address reads 0.
- R3: A write to the reload register has no effect while run is set.
- R4: A control write that sets run while the timer is stopped loads the count with the reload value. The count reads that value on the next cycle.
- R5: While running, the count drops by exactly one per tick and holds its value in cycles without a tick.
- R6: While running, a tick seen when the count is 1 sets the raw flag and reloads the count. A reload value of N therefore raises the flag on every Nth tick, which is a rate of 32768/N Hz.
- R7: A reload value of 0 acts as a period of one tick. The count reads 1 after start, and every tick raises the flag.
- R8: Clearing run freezes the count, and ticks then change neither the count nor the flag.
- R9: Setting run again after a stop restarts the count from the reload value, not from the frozen value.
- R10: A one-cycle clear pulse drops the raw flag. If a new event and a clear arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per 32768 Hz period |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_clr | input | 1 | One-cycle clear of the raw flag |
| evt_flag | output | 1 | Raw periodic interrupt flag |

## Verification
The assertions assume that the bus carries at most one access per cycle. They also assume that tick_en is a single-cycle strobe rather than a level. The stimulus only ever pulses tick_en for one cycle, and it drives write and clear pulses on the falling edge. Each pulse therefore covers exactly one rising edge. The bench deliberately lines up a clear with the event tick to reach the tie case of R10.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h28;

    localparam int RUN_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_RELOAD,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic valid;
        reg_sel_e sel;
        logic [DATA_W-1:0] data;
    } wr_cmd_s;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_COUNT: decode_addr = SEL_COUNT;
            OFS_RELOAD: decode_addr = SEL_RELOAD;
            OFS_CTRL: decode_addr = SEL_CTRL;
            default: decode_addr = SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  reload,
    output logic              run,
    output logic              start
);
    localparam int PAD_W = DATA_W - CNT_W;

    wr_cmd_s cmd;
    reg_sel_e rsel;
    logic unused_wdata;

    assign unused_wdata = ^wdata;
    assign cmd.valid = wr;
    assign cmd.sel = decode_addr(addr);
    assign cmd.data = wdata;
    assign rsel = decode_addr(addr);

    assign start = cmd.valid && (cmd.sel == SEL_CTRL) && cmd.data[RUN_BIT] && !run;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
            run <= 1'b0;
        end else if (cmd.valid) begin
            if (cmd.sel == SEL_RELOAD && !run)
                reload <= cmd.data[CNT_W-1:0];
            if (cmd.sel == SEL_CTRL)
                run <= cmd.data[RUN_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        case (rsel)
            SEL_COUNT: rdata = {{PAD_W{1'b0}}, count};
            SEL_RELOAD: rdata = {{PAD_W{1'b0}}, reload};
            SEL_CTRL: rdata[RUN_BIT] = run;
            default: rdata = '0;
        endcase
    end

    AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(reload)); // R3
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] period;

    assign period = (reload == '0) ? ONE : reload;
    assign evt = run && tick && (count <= ONE);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (start)
            count <= period;
        else if (run && tick)
            count <= evt ? period : count - ONE;
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start |=> count == (($past(reload) == '0) ? ONE : $past(reload))); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !start) |=> $stable(count)); // R5
    AST_FROZEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(count)); // R8
    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> count != '0); // R7
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        set |=> flag); // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag); // R10
endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_clr,
    output logic              evt_flag
);
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;
    logic run;
    logic start;
    logic evt;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .count(count), .rdata(bus_rdata), .reload(reload), .run(run), .start(start)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .run(run), .start(start), .tick(tick_en),
        .reload(reload), .count(count), .evt(evt)
    );

    tmr_flag u_flag (
        .clk(clk), .rst(rst), .set(evt), .clr(evt_clr), .flag(evt_flag)
    );

    AST_STOPPED_NO_EVT: assert property (@(posedge clk) disable iff (rst)
        (!run && !evt_flag) |=> !evt_flag); // R8
endmodule

// File: tb/test_tmr_periodic.sv
module test_tmr_periodic;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic evt_clr = 1'b0;
    logic evt_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    tmr_periodic i_tmr_periodic (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_clr(evt_clr), .evt_flag(evt_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1 count", 8'h20, 0);
        rd_check("R1 reload", 8'h24, 0);
        rd_check("R1 ctrl", 8'h28, 0);
        check("R1 flag", 32'(evt_flag), 0);
        rd_check("R2 unmapped", 8'h2C, 0);
    endtask

    task automatic t_map();
        wr(8'h24, 32'h0000_0005);
        rd_check("R2 reload readback", 8'h24, 5);
        wr(8'h28, 32'hFFFF_FFFD);
        rd_check("R2 ctrl other bits", 8'h28, 0);
        rd_check("R2 count idle", 8'h20, 0);
    endtask

    task automatic t_start();
        wr(8'h28, 32'h2);
        rd_check("R2 ctrl run", 8'h28, 2);
        rd_check("R4 count after start", 8'h20, 5);
        ticks(1);
        rd_check("R5 one tick", 8'h20, 4);
        repeat (5) @(negedge clk);
        rd_check("R5 hold without tick", 8'h20, 4);
        wr(8'h24, 32'h9);
        rd_check("R3 reload locked", 8'h24, 5);
    endtask

    task automatic t_period();
        ticks(3);
        rd_check("R6 count at 1", 8'h20, 1);
        check("R6 no early flag", 32'(evt_flag), 0);
        ticks(1);
        check("R6 flag on expiry", 32'(evt_flag), 1);
        rd_check("R6 reloaded", 8'h20, 5);
        clear_flag();
        check("R10 clear", 32'(evt_flag), 0);
    endtask

    task automatic t_rate();
        wr(8'h28, 0);
        wr(8'h24, 32768 / 8192);
        wr(8'h28, 2);
        ticks(3);
        check("R6 rate not yet", 32'(evt_flag), 0);
        ticks(1);
        check("R6 rate 8192Hz", 32'(evt_flag), 1);
        clear_flag();
    endtask

    task automatic t_zero();
        wr(8'h28, 0);
        wr(8'h24, 0);
        wr(8'h28, 2);
        rd_check("R7 count after start", 8'h20, 1);
        ticks(1);
        check("R7 flag each tick", 32'(evt_flag), 1);
        rd_check("R7 count stays 1", 8'h20, 1);
        clear_flag();
        ticks(1);
        check("R7 flag again", 32'(evt_flag), 1);
        clear_flag();
    endtask

    task automatic t_freeze();
        wr(8'h28, 0);
        wr(8'h24, 6);
        wr(8'h28, 2);
        ticks(2);
        rd_check("R5 two ticks", 8'h20, 4);
        wr(8'h28, 0);
        ticks(6);
        rd_check("R8 frozen count", 8'h20, 4);
        check("R8 no flag when stopped", 32'(evt_flag), 0);
        wr(8'h28, 2);
        rd_check("R9 restart from reload", 8'h20, 6);
    endtask

    task automatic t_race();
        wr(8'h28, 0);
        wr(8'h24, 1);
        wr(8'h28, 2);
        @(negedge clk);
        tick_en = 1'b1; evt_clr = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; evt_clr = 1'b0;
        check("R10 set wins over clear", 32'(evt_flag), 1);
        clear_flag();
        check("R10 clear after race", 32'(evt_flag), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_start();
        t_period();
        t_rate();
        t_zero();
        t_freeze();
        t_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule